// File: doc/BRIEF.md
# Carrier-Synchronous Demodulating Integrator

This block sits behind the decimation filters of a multi-channel resolver front end, one lane per channel (typically sine and cosine). Each decimated sample is rectified by the sign of the excitation carrier: kept when the carrier is positive and negated when it is negative. The block then sums a programmable number of rectified samples into one baseband word. With the count set to the number of filter samples in one carrier period, the block emits one amplitude word per carrier period for each channel.

The carrier polarity reaches the block before the matching sample has passed through the modulator and filter. A programmable delay, counted in sample strobes, shifts the polarity so that it lines up with the data. A shared master enable gates every lane. When it rises, every lane whose own enable is set clears its sum and starts a new period on the same clock edge. The sine and cosine words therefore always cover the same window of samples.

Top module: `demod_integrator`

## Requirements
- R1: Samples are signed two's complement. An accepted sample is added as-is while the effective polarity is 1, and added negated while it is 0.
- R2: After `iosr` accepted samples, the lane's `out_data` field holds the sum of their rectified values and its `out_valid` bit is high for exactly one cycle. Both change on the clock edge that accepts the last sample of the period.
- R3: No `out_valid` pulse occurs before the period's last sample is accepted. A pulse only ever follows an accepted sample.
- R4: Between pulses a lane's `out_data` holds its last result, whatever the inputs do.
- R5: Lanes that are enabled when `master_en` rises accept the same samples, so their `out_valid` pulses coincide.
- R6: While `master_en` is low, no lane accepts samples or pulses `out_valid`. On the first cycle a lane becomes active (`master_en` and its `ch_en` bit both high), it discards any sample present, clears its partial sum and restarts its count.
- R7: A lane whose `ch_en` bit is 0 never pulses `out_valid`, and its `out_data` keeps its previous value.
- R8: With `phase_dly` = d > 0, the effective polarity is the `carrier_pol` value that was present d sample strobes earlier. Every `samp_valid` strobe counts, whether or not a lane accepts it, and strobes before reset count as polarity 0. With d = 0 the current `carrier_pol` is used. Values above MAX_DLY act as MAX_DLY.
- R9: The sum never overflows. `iosr` = MAX_IOSR samples of the most negative input with polarity 0 gives +2^(W-1)·MAX_IOSR.
- R10: `iosr` = 1 produces a result for every accepted sample, and `iosr` = 0 behaves as 1. Values above MAX_IOSR act as MAX_IOSR.
- R11: After reset, `out_valid` is all zero and `out_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Master enable shared by all lanes |
| ch_en | input | NCH | Per-lane enable |
| carrier_pol | input | 1 | Carrier sign from the generator, 1 = positive |
| phase_dly | input | DW | Polarity delay in sample strobes |
| iosr | input | IW | Samples summed per period |
| samp_valid | input | 1 | Strobe marking a new sample on every lane |
| samp_data | input | NCH·W | Signed samples, lane c in bits [c·W +: W] |
| out_valid | output | NCH | One-cycle result strobe per lane |
| out_data | output | NCH·AW | Signed results, lane c in bits [c·AW +: AW] |

## Verification
The overflow property relies on `iosr` never exceeding MAX_IOSR and on samples being in range. The clamp guarantees the first, and the bench drives at most the full-scale negative code. The hold property assumes `out_data` moves only on a result strobe. This holds only if reset is the sole other writer, so the bench changes `iosr`, `phase_dly` and `ch_en` only while `master_en` is low. The bench tracks the polarity history itself, counting every strobe, including strobes presented while lanes are idle. The start cycle is tested by placing a sample exactly on the `master_en` rising edge.

// File: rtl/rdi_pkg.sv
`timescale 1ns/1ps
package rdi_pkg;
   // ceiling log2 with a floor of one bit, for select and count widths
   function automatic int clog2_min1(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r < 1) ? 1 : r;
   endfunction

   // accumulator width: sample, growth over the sum, one bit for negating the minimum code
   function automatic int acc_width(input int w, input int max_iosr);
      return w + clog2_min1(max_iosr) + 1;
   endfunction
endpackage

// File: rtl/rdi_pol_align.sv
`timescale 1ns/1ps
module rdi_pol_align #(
   parameter int MAX_DLY = 7,
   parameter int DW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          samp_valid,
   input  logic          carrier_pol,
   input  logic [DW-1:0] phase_dly,
   output logic          pol_out
);
   generate
      if (MAX_DLY == 0) begin : g_direct
         assign pol_out = carrier_pol;
      end else begin : g_delay
         logic [MAX_DLY-1:0] hist_q;
         logic [DW-1:0]      sel;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q <= '0;
            end else if (samp_valid) begin
               for (int i = MAX_DLY - 1; i > 0; i--) hist_q[i] <= hist_q[i-1];
               hist_q[0] <= carrier_pol;
            end
         end

         always_comb begin
            sel = (phase_dly > DW'(MAX_DLY)) ? DW'(MAX_DLY) : phase_dly;
            pol_out = (sel == '0) ? carrier_pol : hist_q[sel - DW'(1)];
         end

         // R8: a delayed polarity only moves on a sample strobe
         p_pol_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (phase_dly != '0 && $stable(phase_dly) && !$past(samp_valid)) |-> $stable(pol_out));
      end
   endgenerate
endmodule

// File: rtl/rdi_lane.sv
`timescale 1ns/1ps
module rdi_lane #(
   parameter int W        = 12,
   parameter int MAX_IOSR = 32,
   parameter int AW       = 18,
   parameter int IW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          pol,
   input  logic [IW-1:0] iosr,
   input  logic          samp_valid,
   input  logic [W-1:0]  samp,
   output logic          out_valid,
   output logic [AW-1:0] out_data
);
   logic          run_q;
   logic [IW-1:0] cnt_q;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] s_ext, term, acc_nxt;
   logic [IW-1:0] last_idx;

   always_comb begin
      if (iosr == '0)                 last_idx = '0;
      else if (iosr > IW'(MAX_IOSR))  last_idx = IW'(MAX_IOSR - 1);
      else                            last_idx = iosr - IW'(1);
   end

   assign s_ext   = {{(AW-W){samp[W-1]}}, samp};
   assign term    = pol ? s_ext : (~s_ext + AW'(1));
   assign acc_nxt = acc_q + term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         cnt_q     <= '0;
         acc_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         run_q     <= active;
         out_valid <= 1'b0;
         if (active && !run_q) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else if (active && samp_valid) begin
            if (cnt_q >= last_idx) begin
               out_data  <= acc_nxt;
               out_valid <= 1'b1;
               acc_q     <= '0;
               cnt_q     <= '0;
            end else begin
               acc_q <= acc_nxt;
               cnt_q <= cnt_q + IW'(1);
            end
         end
      end
   end

   // R3: a result strobe is always caused by an accepted sample
   p_valid_after_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(samp_valid && active && run_q));
   // R4: the result only moves with its strobe
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
   // R9: adding a rectified sample never wraps the sum
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && run_q && samp_valid) |->
         !((acc_q[AW-1] == term[AW-1]) && (acc_nxt[AW-1] != acc_q[AW-1])));
   // R2: the sample count stays inside one period
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < IW'(MAX_IOSR));
endmodule

// File: rtl/demod_integrator.sv
`timescale 1ns/1ps
module demod_integrator #(
   parameter int NCH      = 2,
   parameter int W        = 12,
   parameter int MAX_IOSR = 32,
   parameter int MAX_DLY  = 7,
   parameter int AW       = rdi_pkg::acc_width(W, MAX_IOSR),
   parameter int IW       = rdi_pkg::clog2_min1(MAX_IOSR + 1),
   parameter int DW       = rdi_pkg::clog2_min1(MAX_DLY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic [NCH-1:0]    ch_en,
   input  logic              carrier_pol,
   input  logic [DW-1:0]     phase_dly,
   input  logic [IW-1:0]     iosr,
   input  logic              samp_valid,
   input  logic [NCH*W-1:0]  samp_data,
   output logic [NCH-1:0]    out_valid,
   output logic [NCH*AW-1:0] out_data
);
   localparam int AW_MIN = rdi_pkg::acc_width(W, MAX_IOSR);

   generate
      if (NCH < 1)           begin : g_bad_nch  $error("NCH must be at least 1");            end
      if (W < 2)             begin : g_bad_w    $error("W must be at least 2");              end
      if (MAX_IOSR < 1)      begin : g_bad_iosr $error("MAX_IOSR must be at least 1");       end
      if (MAX_DLY < 0)       begin : g_bad_dly  $error("MAX_DLY must not be negative");      end
      if (AW < AW_MIN)       begin : g_bad_aw   $error("AW too narrow for MAX_IOSR");        end
      if ((1 << IW) <= MAX_IOSR) begin : g_bad_iw $error("IW cannot hold MAX_IOSR");         end
   endgenerate

   logic pol_eff;

   rdi_pol_align #(.MAX_DLY(MAX_DLY), .DW(DW)) u_pol (
      .clk         (clk),
      .rst_n       (rst_n),
      .samp_valid  (samp_valid),
      .carrier_pol (carrier_pol),
      .phase_dly   (phase_dly),
      .pol_out     (pol_eff)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_lane
         rdi_lane #(.W(W), .MAX_IOSR(MAX_IOSR), .AW(AW), .IW(IW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .active     (master_en & ch_en[c]),
            .pol        (pol_eff),
            .iosr       (iosr),
            .samp_valid (samp_valid),
            .samp       (samp_data[c*W +: W]),
            .out_valid  (out_valid[c]),
            .out_data   (out_data[c*AW +: AW])
         );
      end
   endgenerate

   // R6: no lane produces a result while the master enable is low
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> (out_valid == '0));
endmodule

// File: tb/demod_integrator_test.sv
`timescale 1ns/1ps
module demod_integrator_test;
   localparam int NCH = 2;
   localparam int W   = 12;
   localparam int AW  = 18;
   localparam int IW  = 6;
   localparam int DW  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              master_en = 1'b0;
   logic [NCH-1:0]    ch_en = '0;
   logic              carrier_pol = 1'b0;
   logic [DW-1:0]     phase_dly = '0;
   logic [IW-1:0]     iosr = IW'(4);
   logic              samp_valid = 1'b0;
   logic [NCH*W-1:0]  samp_data = '0;
   logic [NCH-1:0]    out_valid;
   logic [NCH*AW-1:0] out_data;

   int checks = 0;
   int failures = 0;
   bit hist [0:1023];
   int nsent = 0;
   int dly_cfg = 0;
   bit eff_pol;

   always #2.5 clk = ~clk;

   demod_integrator uut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .ch_en(ch_en),
      .carrier_pol(carrier_pol), .phase_dly(phase_dly), .iosr(iosr),
      .samp_valid(samp_valid), .samp_data(samp_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic int lane_out(input int c);
      logic [AW-1:0] v;
      v = out_data[c*AW +: AW];
      return int'($signed(v));
   endfunction

   function automatic int rect(input bit p, input int v);
      return p ? v : -v;
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // one sample strobe; computes the polarity the block should apply (R8)
   task automatic strobe(input bit p, input int a, input int b, input bit start_edge);
      @(negedge clk);
      if (dly_cfg == 0)           eff_pol = p;
      else if (nsent >= dly_cfg)  eff_pol = hist[nsent - dly_cfg];
      else                        eff_pol = 1'b0;
      if (start_edge) master_en = 1'b1;
      samp_valid  = 1'b1;
      carrier_pol = p;
      samp_data   = {b[W-1:0], a[W-1:0]};
      hist[nsent] = p;
      nsent++;
      @(negedge clk);
      samp_valid = 1'b0;
   endtask

   task automatic send(input bit p, input int a, input int b);
      strobe(p, a, b, 1'b0);
   endtask

   task automatic start_run(input logic [NCH-1:0] en, input int n, input int d);
      @(negedge clk);
      master_en = 1'b0;
      @(negedge clk);
      ch_en = en;
      iosr = IW'(n);
      phase_dly = DW'(d);
      dly_cfg = d;
      @(negedge clk);
      master_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R11 valid", int'(out_valid), 0);
      chk("R11 lane0", lane_out(0), 0);
      chk("R11 lane1", lane_out(1), 0);
   endtask

   task automatic t_basic();
      int e0, e1;
      bit pp [4];
      int a [4];
      int b [4];
      pp = '{1, 1, 0, 0};
      a  = '{10, 20, -5, 7};
      b  = '{-100, 50, 3, -8};
      e0 = 0; e1 = 0;
      start_run(2'b11, 4, 0);
      for (int i = 0; i < 4; i++) begin
         send(pp[i], a[i], b[i]);
         e0 += rect(eff_pol, a[i]);
         e1 += rect(eff_pol, b[i]);
         if (i < 3) chk("R3 early valid", int'(out_valid), 0);
      end
      chk("R2 valid pulse", int'(out_valid), 3);
      chk("R1 lane0 sum", lane_out(0), e0);
      chk("R1 lane1 sum", lane_out(1), e1);
      @(negedge clk);
      chk("R2 single-cycle pulse", int'(out_valid), 0);
      repeat (3) @(negedge clk);
      chk("R4 hold idle", lane_out(0), e0);
      send(1, 300, 300);
      send(0, 400, 400);
      chk("R4 hold mid-period", lane_out(0), e0);
      chk("R4 hold mid-period lane1", lane_out(1), e1);
   endtask

   task automatic t_restart();
      @(negedge clk);
      master_en = 1'b0;
      send(1, 900, 900);
      chk("R6 no accept when master low", int'(out_valid), 0);
      strobe(1, 500, 500, 1'b1);
      chk("R6 start-cycle sample", int'(out_valid), 0);
      for (int i = 0; i < 4; i++) send(1, 1, 2);
      chk("R6 restart valid", int'(out_valid), 3);
      chk("R6 cleared partial lane0", lane_out(0), 4);
      chk("R6 cleared partial lane1", lane_out(1), 8);
   endtask

   task automatic t_chdis();
      start_run(2'b01, 4, 0);
      for (int i = 0; i < 4; i++) begin
         send(1, 3, 77);
         if (out_valid[1]) chk("R7 disabled strobe", 1, 0);
      end
      chk("R7 enabled lane only", int'(out_valid), 1);
      chk("R7 lane0 sum", lane_out(0), 12);
      chk("R7 disabled lane holds", lane_out(1), 8);
   endtask

   task automatic t_sync();
      start_run(2'b11, 3, 0);
      for (int k = 0; k < 2; k++) begin
         send(1, 5, 6);
         send(0, 5, 6);
         chk("R5 no early strobe", int'(out_valid), 0);
         send(1, 5, 6);
         chk("R5 coinciding strobes", int'(out_valid), 3);
         chk("R5 lane0", lane_out(0), 5);
         chk("R5 lane1", lane_out(1), 6);
      end
   endtask

   task automatic t_phase();
      int e0;
      bit pp [6];
      pp = '{1, 0, 0, 1, 1, 0};
      start_run(2'b11, 4, 2);
      e0 = 0;
      for (int i = 0; i < 4; i++) begin
         send(pp[i], 100 + i, 0);
         e0 += rect(eff_pol, 100 + i);
      end
      chk("R8 delayed polarity", lane_out(0), e0);
      start_run(2'b11, 2, 7);
      e0 = 0;
      for (int i = 0; i < 2; i++) begin
         send(pp[i+4], 40 + i, 0);
         e0 += rect(eff_pol, 40 + i);
      end
      chk("R8 max delay", lane_out(0), e0);
   endtask

   task automatic t_full();
      start_run(2'b11, 32, 0);
      for (int i = 0; i < 32; i++) send(0, -2048, 2047);
      chk("R9 full-scale valid", int'(out_valid), 3);
      chk("R9 max positive", lane_out(0), 65536);
      chk("R9 max negative", lane_out(1), -65504);
   endtask

   task automatic t_small();
      start_run(2'b11, 1, 0);
      send(1, 11, -12);
      chk("R10 iosr1 valid", int'(out_valid), 3);
      chk("R10 iosr1 data", lane_out(0), 11);
      send(0, 11, -12);
      chk("R10 iosr1 next", lane_out(1), 12);
      start_run(2'b11, 0, 0);
      send(1, 33, 0);
      chk("R10 iosr0 valid", int'(out_valid), 3);
      chk("R10 iosr0 data", lane_out(0), 33);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_restart();
      t_chdis();
      t_sync();
      t_phase();
      t_full();
      t_small();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule